// File: doc/BRIEF.md
# Fractional Ratio Clock Synthesizer

This block derives a slower auxiliary clock from a reference clock using a programmable rational ratio of a numerator N over a denominator D. A phase accumulator adds N on every enabled reference edge. When the sum reaches D, D is taken off and an overflow is marked. Each overflow drives a pulse one reference cycle wide on `pulse_out`, which gives an average pulse rate of Fin·N/D. A second output, `square_out`, toggles on every overflow and so carries a square wave at Fin·N/(2·D).

The ratio pair is captured only on a load strobe. The strobe also clears the phase, so the new ratio starts from a clean state. A captured pair is valid only when N is non-zero, D is non-zero, and 2·N is strictly less than D. Any other pair raises the error flag and keeps both outputs silent until a valid pair is loaded. When D is an exact multiple of N, the pulses fall at evenly spaced intervals. In every other case, the interval alternates between the two integers on either side of D/N.

Top module: `frac_clk_synth`

## Requirements
- R1: After reset, `pulse_out`, `square_out` and `cfg_err` are 0, and both outputs stay 0 while no valid ratio has been loaded, even with `enable` high.
- R2: A clock edge with `load` high captures `ratio_num` and `ratio_den`, clears the accumulator and `square_out`, and drives `pulse_out` to 0. The following enabled edge is edge n=1 of the new phase.
- R3: With a valid ratio and `enable` high, after enabled edge n of the phase, `pulse_out` is 1 exactly when floor(n·N/D) differs from floor((n-1)·N/D).
- R4: After enabled edge n, `square_out` equals the least significant bit of floor(n·N/D), so it toggles once per pulse.
- R5: For a valid ratio, `pulse_out` is never high in two consecutive cycles.
- R6: When D is an integer multiple of N, consecutive pulses are exactly D/N cycles apart.
- R7: A load with N=0, D=0 or 2·N≥D sets `cfg_err` to 1 after that edge and holds both outputs at 0. A later valid load clears `cfg_err` to 0.
- R8: An edge with `enable` low drives both outputs to 0 and clears the accumulator. The phase restarts at n=1 on the next enabled edge.
- R9: When `load` coincides with an edge that would otherwise overflow, the load wins: both outputs read 0 after that edge.
- R10: Changes on `ratio_num` or `ratio_den` without `load` have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Synthesizer run enable |
| ratio_den | input | 12 | Denominator D, captured on load |
| ratio_num | input | 12 | Numerator N, captured on load |
| load | input | 1 | Capture strobe for N and D; restarts the phase |
| pulse_out | output | 1 | One-cycle pulses at Fin·N/D |
| square_out | output | 1 | Square wave at Fin·N/(2·D) |
| cfg_err | output | 1 | Last loaded ratio is invalid |

## Verification
The load strobe and an accumulator overflow can fall on the same reference edge. The load must take priority: the pending pulse is dropped and the toggle is cleared instead of flipped. The bench provokes this by loading 1/5, running to enabled edge 4, and raising `load` with a new ratio on edge 5, where the old ratio would overflow. It then expects both outputs to be 0 and the new phase to follow the arithmetic model from n=0. The same arithmetic model, built from floor(n·N/D), judges every cycle of the exhaustive sweep over small denominators.

// File: rtl/frac_synth_pkg.sv
package frac_synth_pkg;

   typedef enum logic [1:0] {
      SYN_IDLE  = 2'd0,
      SYN_RUN   = 2'd1,
      SYN_FAULT = 2'd2
   } syn_mode_e;

endpackage

// File: rtl/frac_cfg_check.sv
module frac_cfg_check
   import frac_synth_pkg::*;
#(
   parameter int RATIO_W = 12
) (
   input  logic               clk_in,
   input  logic               rst_n,
   input  logic               load,
   input  logic [RATIO_W-1:0] num_in,
   input  logic [RATIO_W-1:0] den_in,
   output logic [RATIO_W-1:0] num_q,
   output logic [RATIO_W-1:0] den_q,
   output syn_mode_e          mode_q
);

   localparam int DBL_W = RATIO_W + 1;

   logic [DBL_W-1:0] num_dbl;
   logic             pair_ok;

   assign num_dbl = {num_in, 1'b0};
   assign pair_ok = (num_in != '0) && (den_in != '0) && (num_dbl < {1'b0, den_in});

   always_ff @(posedge clk_in or negedge rst_n) begin
      if (!rst_n) begin
         num_q  <= '0;
         den_q  <= '0;
         mode_q <= SYN_IDLE;
      end else if (load) begin
         num_q  <= num_in;
         den_q  <= den_in;
         mode_q <= pair_ok ? SYN_RUN : SYN_FAULT;
      end
   end

   AST_FAULT_ON_BAD_LOAD: assert property (@(posedge clk_in) disable iff (!rst_n)
      (load && !pair_ok) |=> (mode_q == SYN_FAULT)); // R7

endmodule

// File: rtl/frac_phase_acc.sv
module frac_phase_acc #(
   parameter int RATIO_W = 12
) (
   input  logic               clk_in,
   input  logic               rst_n,
   input  logic               run,
   input  logic [RATIO_W-1:0] num,
   input  logic [RATIO_W-1:0] den,
   output logic [RATIO_W-1:0] acc_q,
   output logic               wrap_now,
   output logic               pulse_q
);

   localparam int SUM_W = RATIO_W + 1;

   logic [SUM_W-1:0] sum;
   logic [SUM_W-1:0] sum_wrapped;

   assign sum         = {1'b0, acc_q} + {1'b0, num};
   assign wrap_now    = run && (sum >= {1'b0, den});
   assign sum_wrapped = sum - {1'b0, den};

   always_ff @(posedge clk_in or negedge rst_n) begin
      if (!rst_n) begin
         acc_q   <= '0;
         pulse_q <= 1'b0;
      end else if (!run) begin
         acc_q   <= '0;
         pulse_q <= 1'b0;
      end else if (wrap_now) begin
         acc_q   <= sum_wrapped[RATIO_W-1:0];
         pulse_q <= 1'b1;
      end else begin
         acc_q   <= sum[RATIO_W-1:0];
         pulse_q <= 1'b0;
      end
   end

   AST_IDLE_CLEARS_ACC: assert property (@(posedge clk_in) disable iff (!rst_n)
      !run |=> (acc_q == '0) && !pulse_q); // R8

endmodule

// File: rtl/frac_toggle_out.sv
module frac_toggle_out #(
   parameter bit SQUARE_EN = 1'b1
) (
   input  logic clk_in,
   input  logic rst_n,
   input  logic run,
   input  logic wrap_now,
   output logic square_q
);

   generate
      if (SQUARE_EN) begin : g_square
         always_ff @(posedge clk_in or negedge rst_n) begin
            if (!rst_n)
               square_q <= 1'b0;
            else if (!run)
               square_q <= 1'b0;
            else if (wrap_now)
               square_q <= ~square_q;
         end
      end else begin : g_no_square
         assign square_q = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/frac_clk_synth.sv
module frac_clk_synth
   import frac_synth_pkg::*;
#(
   parameter int RATIO_W   = 12,
   parameter bit SQUARE_EN = 1'b1
) (
   input  logic               clk_in,
   input  logic               rst_n,
   input  logic               enable,
   input  logic [RATIO_W-1:0] ratio_den,
   input  logic [RATIO_W-1:0] ratio_num,
   input  logic               load,
   output logic               pulse_out,
   output logic               square_out,
   output logic               cfg_err
);

   generate
      if (RATIO_W < 2) begin : g_bad_width
         $error("frac_clk_synth: RATIO_W must be at least 2");
      end
   endgenerate

   logic [RATIO_W-1:0] num_q;
   logic [RATIO_W-1:0] den_q;
   logic [RATIO_W-1:0] acc_q;
   syn_mode_e          mode_q;
   logic               run;
   logic               wrap_now;
   logic               pulse_q;
   logic               square_q;

   frac_cfg_check #(.RATIO_W(RATIO_W)) u_cfg (
      .clk_in (clk_in),
      .rst_n  (rst_n),
      .load   (load),
      .num_in (ratio_num),
      .den_in (ratio_den),
      .num_q  (num_q),
      .den_q  (den_q),
      .mode_q (mode_q)
   );

   assign run = enable && !load && (mode_q == SYN_RUN);

   frac_phase_acc #(.RATIO_W(RATIO_W)) u_acc (
      .clk_in   (clk_in),
      .rst_n    (rst_n),
      .run      (run),
      .num      (num_q),
      .den      (den_q),
      .acc_q    (acc_q),
      .wrap_now (wrap_now),
      .pulse_q  (pulse_q)
   );

   frac_toggle_out #(.SQUARE_EN(SQUARE_EN)) u_tog (
      .clk_in   (clk_in),
      .rst_n    (rst_n),
      .run      (run),
      .wrap_now (wrap_now),
      .square_q (square_q)
   );

   assign pulse_out  = pulse_q;
   assign square_out = square_q;
   assign cfg_err    = (mode_q == SYN_FAULT);

   AST_ACC_BELOW_DEN: assert property (@(posedge clk_in) disable iff (!rst_n)
      (mode_q == SYN_RUN) |-> (acc_q < den_q)); // R3
   AST_NO_BACK_TO_BACK: assert property (@(posedge clk_in) disable iff (!rst_n)
      pulse_out |=> !pulse_out); // R5
   AST_SQUARE_ON_PULSE: assert property (@(posedge clk_in) disable iff (!rst_n)
      $rose(square_out) |-> pulse_out); // R4
   AST_LOAD_WINS: assert property (@(posedge clk_in) disable iff (!rst_n)
      load |=> (!pulse_out && !square_out)); // R9
   AST_ERR_SILENT: assert property (@(posedge clk_in) disable iff (!rst_n)
      cfg_err |-> (!pulse_out && !square_out)); // R7
   AST_DISABLE_SILENT: assert property (@(posedge clk_in) disable iff (!rst_n)
      !enable |=> (!pulse_out && !square_out)); // R8

endmodule

// File: tb/frac_clk_synth_tb.sv
module frac_clk_synth_tb;

   logic        clk_in = 1'b0;
   logic        rst_n  = 1'b0;
   logic        enable = 1'b0;
   logic [11:0] ratio_den = '0;
   logic [11:0] ratio_num = '0;
   logic        load = 1'b0;
   logic        pulse_out;
   logic        square_out;
   logic        cfg_err;

   int checks   = 0;
   int failures = 0;
   int n_edge   = 0;
   int cur_num  = 0;
   int cur_den  = 1;
   int last_pulse_n = -1;
   bit prev_pulse   = 1'b0;
   bit done         = 1'b0;

   always #5 clk_in = ~clk_in;

   frac_clk_synth u_dut (
      .clk_in     (clk_in),
      .rst_n      (rst_n),
      .enable     (enable),
      .ratio_den  (ratio_den),
      .ratio_num  (ratio_num),
      .load       (load),
      .pulse_out  (pulse_out),
      .square_out (square_out),
      .cfg_err    (cfg_err)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d n=%0d N=%0d D=%0d",
                  tag, act, exp, n_edge, cur_num, cur_den);
      end
   endtask

   function automatic longint fl(input int n, input int num, input int den);
      return (longint'(n) * num) / den;
   endfunction

   task automatic do_load(input int num, input int den);
      ratio_num = num[11:0];
      ratio_den = den[11:0];
      load = 1'b1;
      @(posedge clk_in); #1;
      load = 1'b0;
      cur_num = num; cur_den = den;
      n_edge = 0; last_pulse_n = -1; prev_pulse = 1'b0;
   endtask

   // one enabled edge of a valid ratio, checked against the floor model
   task automatic step_valid();
      bit ep;
      int es;
      @(posedge clk_in); #1;
      n_edge++;
      ep = fl(n_edge, cur_num, cur_den) != fl(n_edge - 1, cur_num, cur_den);
      es = int'(fl(n_edge, cur_num, cur_den) % 2);
      chk(pulse_out == ep, "R3 pulse_out", pulse_out, ep);
      chk(square_out == es[0], "R4 square_out", square_out, es);
      if (pulse_out && prev_pulse) chk(1'b0, "R5 back-to-back", 1, 0);
      if (pulse_out && (cur_den % cur_num == 0)) begin
         if (last_pulse_n >= 0)
            chk(n_edge - last_pulse_n == cur_den / cur_num, "R6 spacing",
                n_edge - last_pulse_n, cur_den / cur_num);
         last_pulse_n = n_edge;
      end
      prev_pulse = pulse_out;
   endtask

   task automatic check_quiet(input string tag, input int cycles, input bit err_exp);
      for (int i = 0; i < cycles; i++) begin
         @(posedge clk_in); #1;
         chk(!pulse_out && !square_out, tag, {pulse_out, square_out}, 0);
         chk(cfg_err == err_exp, tag, cfg_err, err_exp);
      end
   endtask

   initial begin : watchdog
      int cyc = 0;
      while (!done && cyc < 150000) begin
         @(posedge clk_in);
         cyc++;
      end
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected=finish", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      repeat (3) @(posedge clk_in);
      #1;
      chk(!pulse_out && !square_out && !cfg_err, "R1 reset", {pulse_out, square_out, cfg_err}, 0);
      rst_n = 1'b1;
      enable = 1'b1;
      check_quiet("R1 no ratio loaded", 6, 1'b0);

      // R2 R3 R4 R5 R6 sweep over small denominators
      for (int d = 3; d <= 24; d++) begin
         for (int x = 1; 2 * x < d; x++) begin
            do_load(x, d);
            chk(!pulse_out && !square_out && !cfg_err, "R2 load restart",
                {pulse_out, square_out, cfg_err}, 0);
            for (int k = 0; k < 2 * d + 3; k++) step_valid();
         end
      end

      // extremes of the 12-bit range
      do_load(2047, 4095);
      for (int k = 0; k < 300; k++) step_valid();
      do_load(1, 4095);
      for (int k = 0; k < 4100; k++) step_valid();

      // R7 invalid ratios
      do_load(0, 10);
      chk(cfg_err == 1'b1, "R7 N=0", cfg_err, 1);
      check_quiet("R7 N=0 quiet", 12, 1'b1);
      do_load(5, 10);
      chk(cfg_err == 1'b1, "R7 2N=D", cfg_err, 1);
      check_quiet("R7 2N=D quiet", 12, 1'b1);
      do_load(7, 10);
      chk(cfg_err == 1'b1, "R7 2N>D", cfg_err, 1);
      check_quiet("R7 2N>D quiet", 12, 1'b1);
      do_load(3, 0);
      chk(cfg_err == 1'b1, "R7 D=0", cfg_err, 1);
      check_quiet("R7 D=0 quiet", 12, 1'b1);
      do_load(4, 9);
      chk(cfg_err == 1'b0, "R7 valid load clears", cfg_err, 0);
      for (int k = 0; k < 20; k++) step_valid();

      // R10 input changes without load
      do_load(3, 10);
      for (int k = 0; k < 5; k++) step_valid();
      ratio_num = 12'd1;
      ratio_den = 12'd7;
      for (int k = 0; k < 25; k++) step_valid(); // R10 still follows 3/10

      // R8 enable low clears, restart on re-enable
      enable = 1'b0;
      check_quiet("R8 disabled quiet", 6, 1'b0);
      enable = 1'b1;
      n_edge = 0; last_pulse_n = -1; prev_pulse = 1'b0;
      for (int k = 0; k < 25; k++) step_valid(); // R8 restart from n=1

      // R9 load on the overflow edge
      do_load(1, 5);
      for (int k = 0; k < 4; k++) step_valid();
      ratio_num = 12'd2;
      ratio_den = 12'd9;
      load = 1'b1;
      @(posedge clk_in); #1;
      load = 1'b0;
      chk(!pulse_out && !square_out, "R9 load beats overflow", {pulse_out, square_out}, 0);
      cur_num = 2; cur_den = 9;
      n_edge = 0; last_pulse_n = -1; prev_pulse = 1'b0;
      for (int k = 0; k < 20; k++) step_valid(); // R9 new phase

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule